// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the mode state machine at the top of a fluorescent lamp ballast controller. It takes digital flags from comparators that watch the supply, the shutdown/end-of-life sense pin, the DC bus sense pin, the timing capacitor and the over-current event counter. From these it walks the controller through five modes: supply lockout, filament preheat, ignition, steady run and a latched fault. It lives beside the oscillator, the comparators and the gate drivers, none of which are part of it.

Each cycle it decodes which gate drivers may switch and whether the timing capacitor and the oscillator control must be discharged. It also decodes which protection checks are armed. The over-current counter runs only while the lamp is preheating or running. The end-of-life window and bus undervoltage checks run only in steady run. All outputs, including a one-hot copy of the mode, come from registers and change together one cycle after the input that causes them.

A fault holds every gate drive low. It is left only through the supply dropping out or the shutdown pin being pulled above its high threshold, and both of those lead to lockout. From lockout the lamp restarts from preheat.

Top module: `ballast_mode_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters lockout: `mode_onehot` = 5'b00001, all three gate enables low, both discharge outputs high, all three check enables low, whatever the flags are.
- R2: In lockout the block moves to preheat when `supply_ok_hi` is 1 and `sd_mid3` is 0 (with `supply_ok_lo` 1). Otherwise it stays in lockout.
- R3: In preheat a rising edge of `tcap_cross` (0 in the previous cycle, 1 now) moves the block to ignition. A level held high gives only one edge.
- R4: In ignition the next rising edge of `tcap_cross` moves the block to run.
- R5: In run, `sd_mid3` = 1 or `sd_lo1` = 1 moves the block to fault.
- R6: In run, `bus_low` = 1 with no fault condition present moves the block to lockout, which drops all gate enables.
- R7: In fault all three gate enables are low, and `tcap_discharge` and `vco_discharge` are both high.
- R8: Fault is left only by `supply_ok_lo` = 0 or `sd_hi5` = 1, and both go to lockout. Any other flag pattern keeps the fault.
- R9: `oc_trip` = 1 forces fault from preheat or run. It has no effect in lockout, ignition or fault.
- R10: `supply_ok_lo` = 0 forces lockout from every mode and overrides every other flag.
- R11: The mode bits are [0] lockout, [1] preheat, [2] ignition, [3] run and [4] fault, with exactly one set. Gate enables are high only in preheat, ignition and run. `oc_count_en` is high in preheat and run. `eol_check_en` and `busuv_check_en` are high only in run. The discharge outputs are high only in lockout and fault.
- R12: Outputs change only at a clock edge. A flag change shows on the outputs after the next rising edge and not before it.
- R13: In ignition, `sd_mid3`, `sd_lo1`, `bus_low` and `oc_trip` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_hi | input | 1 | Supply above upper undervoltage threshold |
| supply_ok_lo | input | 1 | Supply above lower undervoltage threshold |
| sd_hi5 | input | 1 | Shutdown/end-of-life pin above 5.0 V |
| sd_mid3 | input | 1 | Shutdown/end-of-life pin above 3.0 V |
| sd_lo1 | input | 1 | Shutdown/end-of-life pin below 1.0 V |
| bus_low | input | 1 | Bus sense below 3.0 V |
| tcap_cross | input | 1 | Timing capacitor above its threshold |
| oc_trip | input | 1 | Over-current counter fault request |
| hs_gate_en | output | 1 | High-side gate drive enable |
| ls_gate_en | output | 1 | Low-side gate drive enable |
| pfc_gate_en | output | 1 | PFC gate drive enable |
| tcap_discharge | output | 1 | Discharge the timing capacitor |
| vco_discharge | output | 1 | Discharge the oscillator control |
| oc_count_en | output | 1 | Over-current counter enable |
| eol_check_en | output | 1 | End-of-life window check enable |
| busuv_check_en | output | 1 | Bus undervoltage check enable |
| mode_onehot | output | 5 | Current mode, one-hot |

## Verification
The bench brings the block into each of the five modes in turn. In each mode it applies every one of the 256 combinations of the eight flags for a single cycle, with the timing flag low in the cycle before, so a set timing flag is a true rising edge. Each combination has a known next mode. The sweep therefore separates the priority of supply dropout over everything else, fault over bus undervoltage in run, and flags that must be ignored in ignition, lockout and fault. Separate cases hold the timing flag high across several cycles to show that only its edge advances the mode. Other cases sample before the clock edge to show the registered latency.

// File: rtl/ballast_seq_pkg.sv
package ballast_seq_pkg;

    localparam int MODE_W = 5;

    typedef enum logic [MODE_W-1:0] {
        M_LOCK  = 5'b00001,
        M_PRE   = 5'b00010,
        M_IGN   = 5'b00100,
        M_RUN   = 5'b01000,
        M_FAULT = 5'b10000
    } mode_e;

    typedef struct packed {
        logic sup_hi;
        logic sup_lo;
        logic sd_hi5;
        logic sd_mid3;
        logic sd_lo1;
        logic bus_low;
        logic oc_trip;
    } sense_t;

    typedef struct packed {
        logic hs_en;
        logic ls_en;
        logic pfc_en;
        logic tcap_dis;
        logic vco_dis;
        logic oc_en;
        logic eol_en;
        logic bus_en;
    } drive_t;

    function automatic drive_t drive_for(mode_e m);
        drive_t d;
        logic   switching;
        switching  = (m == M_PRE) || (m == M_IGN) || (m == M_RUN);
        d.hs_en    = switching;
        d.ls_en    = switching;
        d.pfc_en   = switching;
        d.tcap_dis = (m == M_LOCK) || (m == M_FAULT);
        d.vco_dis  = (m == M_LOCK) || (m == M_FAULT);
        d.oc_en    = (m == M_PRE) || (m == M_RUN);
        d.eol_en   = (m == M_RUN);
        d.bus_en   = (m == M_RUN);
        return d;
    endfunction

endpackage

// File: rtl/ballast_cross_edge.sv
module ballast_cross_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;

    // A held level must not produce back-to-back edges (R3)
    assert_edge_single_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/ballast_mode_next.sv
module ballast_mode_next
    import ballast_seq_pkg::*;
(
    input  mode_e  cur,
    input  sense_t sense,
    input  logic   tcap_rise,
    output mode_e  nxt
);
    logic eol_hit;

    assign eol_hit = sense.sd_mid3 | sense.sd_lo1;

    always_comb begin
        nxt = cur;
        if (!sense.sup_lo) begin
            nxt = M_LOCK;
        end else begin
            case (cur)
                M_LOCK: begin
                    if (sense.sup_hi && !sense.sd_mid3) nxt = M_PRE;
                end
                M_PRE: begin
                    if (sense.oc_trip)  nxt = M_FAULT;
                    else if (tcap_rise) nxt = M_IGN;
                end
                M_IGN: begin
                    if (tcap_rise) nxt = M_RUN;
                end
                M_RUN: begin
                    if (sense.oc_trip || eol_hit) nxt = M_FAULT;
                    else if (sense.bus_low)       nxt = M_LOCK;
                end
                M_FAULT: begin
                    if (sense.sd_hi5) nxt = M_LOCK;
                end
                default: nxt = M_LOCK;
            endcase
        end
    end

endmodule

// File: rtl/ballast_drive_reg.sv
module ballast_drive_reg
    import ballast_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_e  nxt,
    output drive_t drv_q
);
    always_ff @(posedge clk) begin
        if (rst) drv_q <= drive_for(M_LOCK);
        else     drv_q <= drive_for(nxt);
    end

    // Gate drives and discharge are never asserted together (R11)
    assert_gate_vs_discharge_R11: assert property (@(posedge clk) disable iff (rst)
        drv_q.hs_en |-> (!drv_q.tcap_dis && !drv_q.vco_dis));

endmodule

// File: rtl/ballast_mode_seq.sv
module ballast_mode_seq
    import ballast_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok_hi,
    input  logic              supply_ok_lo,
    input  logic              sd_hi5,
    input  logic              sd_mid3,
    input  logic              sd_lo1,
    input  logic              bus_low,
    input  logic              tcap_cross,
    input  logic              oc_trip,
    output logic              hs_gate_en,
    output logic              ls_gate_en,
    output logic              pfc_gate_en,
    output logic              tcap_discharge,
    output logic              vco_discharge,
    output logic              oc_count_en,
    output logic              eol_check_en,
    output logic              busuv_check_en,
    output logic [MODE_W-1:0] mode_onehot
);
    sense_t sense;
    logic   tcap_rise;
    mode_e  mode_q;
    mode_e  mode_d;
    drive_t drv_q;

    assign sense.sup_hi  = supply_ok_hi;
    assign sense.sup_lo  = supply_ok_lo;
    assign sense.sd_hi5  = sd_hi5;
    assign sense.sd_mid3 = sd_mid3;
    assign sense.sd_lo1  = sd_lo1;
    assign sense.bus_low = bus_low;
    assign sense.oc_trip = oc_trip;

    ballast_cross_edge edge_i (
        .clk   (clk),
        .rst   (rst),
        .level (tcap_cross),
        .rise  (tcap_rise)
    );

    ballast_mode_next next_i (
        .cur       (mode_q),
        .sense     (sense),
        .tcap_rise (tcap_rise),
        .nxt       (mode_d)
    );

    always_ff @(posedge clk) begin
        if (rst) mode_q <= M_LOCK;
        else     mode_q <= mode_d;
    end

    ballast_drive_reg drive_i (
        .clk   (clk),
        .rst   (rst),
        .nxt   (mode_d),
        .drv_q (drv_q)
    );

    assign hs_gate_en     = drv_q.hs_en;
    assign ls_gate_en     = drv_q.ls_en;
    assign pfc_gate_en    = drv_q.pfc_en;
    assign tcap_discharge = drv_q.tcap_dis;
    assign vco_discharge  = drv_q.vco_dis;
    assign oc_count_en    = drv_q.oc_en;
    assign eol_check_en   = drv_q.eol_en;
    assign busuv_check_en = drv_q.bus_en;
    assign mode_onehot    = mode_q;

    assert_mode_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_q) == 1);

    assert_supply_drop_R10: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_lo |=> (mode_q == M_LOCK));

    assert_fault_outputs_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_FAULT) |-> (!hs_gate_en && !ls_gate_en && !pfc_gate_en
                                 && tcap_discharge && vco_discharge));

    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_FAULT && supply_ok_lo && !sd_hi5) |=> (mode_q == M_FAULT));

    assert_oc_preheat_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_PRE && supply_ok_lo && oc_trip) |=> (mode_q == M_FAULT));

    assert_eol_run_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RUN && supply_ok_lo && (sd_mid3 || sd_lo1)) |=> (mode_q == M_FAULT));

    assert_checks_run_only_R11: assert property (@(posedge clk) disable iff (rst)
        (eol_check_en || busuv_check_en) |-> (mode_q == M_RUN));

endmodule

// File: tb/ballast_mode_seq_tb.sv
module ballast_mode_seq_tb_top;

    localparam logic [4:0] E_LOCK  = 5'b00001;
    localparam logic [4:0] E_PRE   = 5'b00010;
    localparam logic [4:0] E_IGN   = 5'b00100;
    localparam logic [4:0] E_RUN   = 5'b01000;
    localparam logic [4:0] E_FAULT = 5'b10000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok_hi = 1'b0, supply_ok_lo = 1'b1, sd_hi5 = 1'b0, sd_mid3 = 1'b0;
    logic sd_lo1 = 1'b0, bus_low = 1'b0, tcap_cross = 1'b0, oc_trip = 1'b0;
    logic hs_gate_en, ls_gate_en, pfc_gate_en, tcap_discharge, vco_discharge;
    logic oc_count_en, eol_check_en, busuv_check_en;
    logic [4:0] mode_onehot;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ballast_mode_seq dut_i (
        .clk(clk), .rst(rst),
        .supply_ok_hi(supply_ok_hi), .supply_ok_lo(supply_ok_lo),
        .sd_hi5(sd_hi5), .sd_mid3(sd_mid3), .sd_lo1(sd_lo1),
        .bus_low(bus_low), .tcap_cross(tcap_cross), .oc_trip(oc_trip),
        .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en), .pfc_gate_en(pfc_gate_en),
        .tcap_discharge(tcap_discharge), .vco_discharge(vco_discharge),
        .oc_count_en(oc_count_en), .eol_check_en(eol_check_en),
        .busuv_check_en(busuv_check_en), .mode_onehot(mode_onehot)
    );

    // {hs, ls, pfc, tcap_dis, vco_dis, oc_en, eol_en, bus_en} per R11 / R7
    function automatic logic [7:0] exp_drive(logic [4:0] m);
        case (m)
            E_LOCK:  return 8'b000_11_000;
            E_PRE:   return 8'b111_00_100;
            E_IGN:   return 8'b111_00_000;
            E_RUN:   return 8'b111_00_111;
            default: return 8'b000_11_000;
        endcase
    endfunction

    // flag bits: [0] lo, [1] hi, [2] sd5, [3] sd3, [4] sd1, [5] bus, [6] tcap edge, [7] oc
    function automatic logic [4:0] exp_next(logic [4:0] m, logic [7:0] c);
        if (!c[0]) return E_LOCK;
        case (m)
            E_LOCK:  return (c[1] && !c[3]) ? E_PRE : E_LOCK;
            E_PRE:   return c[7] ? E_FAULT : (c[6] ? E_IGN : E_PRE);
            E_IGN:   return c[6] ? E_RUN : E_IGN;
            E_RUN:   return (c[7] || c[3] || c[4]) ? E_FAULT : (c[5] ? E_LOCK : E_RUN);
            default: return c[2] ? E_LOCK : E_FAULT;
        endcase
    endfunction

    function automatic string tag_for(logic [4:0] m, logic [7:0] c);
        if (!c[0]) return "R10";
        case (m)
            E_LOCK:  return c[7] ? "R9" : "R2";
            E_PRE:   return c[7] ? "R9" : "R3";
            E_IGN:   return (c[6]) ? "R4" : "R13";
            E_RUN:   return (c[3] || c[4]) ? "R5" : (c[7] ? "R9" : "R6");
            default: return "R8";
        endcase
    endfunction

    function automatic logic [7:0] act_drive();
        return {hs_gate_en, ls_gate_en, pfc_gate_en, tcap_discharge, vco_discharge,
                oc_count_en, eol_check_en, busuv_check_en};
    endfunction

    task automatic check_val(string tag, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic set_flags(logic [7:0] c);
        supply_ok_lo = c[0]; supply_ok_hi = c[1]; sd_hi5 = c[2]; sd_mid3 = c[3];
        sd_lo1 = c[4]; bus_low = c[5]; tcap_cross = c[6]; oc_trip = c[7];
    endtask

    // Leaves the DUT in mode m at a falling edge with tcap_cross low.
    task automatic go_to(logic [4:0] m);
        @(negedge clk);
        rst = 1'b1;
        set_flags(8'b0000_0001);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        if (m != E_LOCK) begin
            supply_ok_hi = 1'b1;
            @(negedge clk);
            if (m != E_PRE) begin
                tcap_cross = 1'b1; @(negedge clk);
                tcap_cross = 1'b0; @(negedge clk);
                if (m != E_IGN) begin
                    tcap_cross = 1'b1; @(negedge clk);
                    tcap_cross = 1'b0; @(negedge clk);
                    if (m != E_RUN) begin
                        sd_lo1 = 1'b1; @(negedge clk);
                        sd_lo1 = 1'b0; @(negedge clk);
                    end
                end
            end
        end
        check_val("R2", {3'b0, mode_onehot}, {3'b0, m}, "setup mode");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] modes [5];
        modes[0] = E_LOCK; modes[1] = E_PRE; modes[2] = E_IGN;
        modes[3] = E_RUN;  modes[4] = E_FAULT;

        // R1: reset wins over flags that would otherwise start preheat
        set_flags(8'b0000_0011);
        repeat (3) @(posedge clk);
        #1;
        check_val("R1", {3'b0, mode_onehot}, {3'b0, E_LOCK}, "reset mode");
        check_val("R1", act_drive(), exp_drive(E_LOCK), "reset drives");

        // R3: a held timing flag advances preheat only once
        go_to(E_PRE);
        tcap_cross = 1'b1;
        repeat (4) @(negedge clk);
        check_val("R3", {3'b0, mode_onehot}, {3'b0, E_IGN}, "held level");
        tcap_cross = 1'b0;
        @(negedge clk);
        tcap_cross = 1'b1;
        @(negedge clk);
        check_val("R4", {3'b0, mode_onehot}, {3'b0, E_RUN}, "second edge");

        // R12: outputs wait for the clock edge
        bus_low = 1'b1;
        #2;
        check_val("R12", {3'b0, mode_onehot}, {3'b0, E_RUN}, "pre-edge mode");
        check_val("R12", act_drive(), exp_drive(E_RUN), "pre-edge drives");
        @(posedge clk); #1;
        check_val("R6", {3'b0, mode_onehot}, {3'b0, E_LOCK}, "bus low in run");
        check_val("R6", act_drive(), exp_drive(E_LOCK), "bus low drives");

        // Sweep: every flag pattern from every mode
        for (int mi = 0; mi < 5; mi++) begin
            for (int ci = 0; ci < 256; ci++) begin
                logic [7:0] c;
                logic [4:0] e;
                c = ci[7:0];
                go_to(modes[mi]);
                set_flags(c);
                #2;
                check_val("R12", {3'b0, mode_onehot}, {3'b0, modes[mi]}, "before edge");
                e = exp_next(modes[mi], c);
                @(posedge clk); #1;
                check_val(tag_for(modes[mi], c), {3'b0, mode_onehot}, {3'b0, e}, "next mode");
                check_val((e == E_FAULT) ? "R7" : "R11", act_drive(), exp_drive(e), "drives");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule